// File: doc/BRIEF.md
# Relocatable Dual-Bank Scratchpad SRAM

This block is a single-cycle on-chip scratchpad memory with two access ports. One port serves the processor's local bus and the other serves a second bus master such as a DMA engine. A base register places the memory on any 64 KB boundary of the 32-bit address space. Every request is compared against that base, and a matching request is served in one clock. Byte, halfword and longword transfers are supported. The storage is built as two physical banks, interleaved on longwords, so both ports can finish in the same cycle when they touch different banks.

The base register is written by the processor through a control-register write and can be read and written by a debug agent. When a processor request hits the memory, the block raises a do-not-cache indication. On the next cycle the block returns its own read data in place of whatever a parallel cache lookup produced. Memory depth is a parameter. Addresses inside the 64 KB window wrap onto the physical array, and memory contents are left uninitialised by reset.

Top module: `reloc_sram`

## Requirements
- R1: A port hits only when its request is high, the valid bit is set and address bits [31:16] equal the base field. A request that misses leaves memory unchanged. `cpu_nocache` follows `cpu_hit`.
- R2: The base register keeps the base field in bits [31:16] and the valid bit in bit 0. Bits [15:1] ignore writes and read back as zero on `dbg_rdata`.
- R3: Reset clears only the valid bit, which blocks all hits. The base field keeps its previous value and memory contents are kept.
- R4: `cfg_we` writes the base register from `cfg_wdata`. `dbg_we` writes it from `dbg_wdata`. If both write in the same cycle, the debug value wins.
- R5: The size code is 00 for a byte, 01 for a halfword and 10 for a longword. Write data is right-justified, and byte lane k of the stored longword is bits [8k+7:8k], with address bits [1:0] giving the lowest lane written. A write changes only the lanes it covers.
- R6: Read data appears on the clock after the request. It is right-justified and zero-extended to the access size.
- R7: A halfword at an odd address, a longword whose address bits [1:0] are nonzero, or size code 11 is misaligned. A misaligned hit raises that port's error output for the one following cycle and leaves memory unchanged.
- R8: Address bit 2 selects the bank. A processor hit and a DMA hit to different banks both complete in the same cycle.
- R9: When both ports hit the same bank in one cycle, the processor access is performed. `dma_wait` is high in that cycle and the DMA access does not take place.
- R10: In the cycle after a processor read hit, `cpu_rdata` carries SRAM data. In every other cycle it carries `cache_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Processor control-register write strobe for the base register |
| cfg_wdata | input | 32 | Processor base-register write value |
| dbg_we | input | 1 | Debug write strobe for the base register |
| dbg_wdata | input | 32 | Debug base-register write value |
| dbg_rdata | output | 32 | Base-register read value for the debug agent |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_size | input | 2 | Processor access size code |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data, right-justified |
| cache_rdata | input | 32 | Data from the parallel cache lookup |
| cpu_hit | output | 1 | Processor request falls in the SRAM window |
| cpu_nocache | output | 1 | Tells the cache not to allocate this access |
| cpu_rdata | output | 32 | Processor read data, with SRAM data overriding cache data |
| cpu_err | output | 1 | Misaligned processor hit, one cycle after the request |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_size | input | 2 | DMA access size code |
| dma_addr | input | 32 | DMA byte address |
| dma_wdata | input | 32 | DMA write data, right-justified |
| dma_hit | output | 1 | DMA request falls in the SRAM window |
| dma_wait | output | 1 | DMA access held off by a same-bank processor access |
| dma_rdata | output | 32 | DMA read data |
| dma_err | output | 1 | Misaligned DMA hit, one cycle after the request |

## Verification
Address decode is tried with a request one 64 KB page above the base and with the base page itself. Each is issued both with the valid bit set and after reset, which separates a compare-only fault from a valid-gating fault. Lane handling is tried with overlapping byte, halfword and longword writes at different offsets to one longword, followed by reads of each size. This exposes a wrong lane shift, a wrong mask or missing zero-extension. Dual-port behaviour is tried with simultaneous traffic to opposite banks and to the same bank. The opposite-bank case shows that both ports complete. The same-bank case shows that the processor is favoured and the DMA write is dropped.

// File: rtl/sram_pkg.sv
// Shared size codes and lane helpers for the relocatable scratchpad SRAM.
// Assumes a 32-bit data path with little-endian byte lanes.
package sram_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam int BASE_LSB = 16;
    localparam int BASE_W   = 32 - BASE_LSB;

    // Byte-lane enable pattern for an access of a given size and offset.
    function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            SZ_BYTE: lane_mask = 4'b0001 << off;
            SZ_HALF: lane_mask = 4'b0011 << off;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

    // True when size and offset do not form a legal aligned access.
    function automatic logic is_misaligned(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            SZ_BYTE: is_misaligned = 1'b0;
            SZ_HALF: is_misaligned = off[0];
            SZ_WORD: is_misaligned = (off != 2'b00);
            default: is_misaligned = 1'b1;
        endcase
    endfunction

    // Right-justify and zero-extend the addressed part of a stored longword.
    function automatic logic [31:0] rd_extract(input logic [31:0] w, input logic [1:0] off,
                                               input logic [1:0] sz);
        logic [31:0] s;
        s = w >> {off, 3'b000};
        case (sz)
            SZ_BYTE: rd_extract = {24'b0, s[7:0]};
            SZ_HALF: rd_extract = {16'b0, s[15:0]};
            default: rd_extract = s;
        endcase
    endfunction

endpackage

// File: rtl/sram_base_reg.sv
// Base/enable register for the SRAM window.
// Only the valid bit is reset. The base field has no reset and holds its value
// across reset. Reserved bits are not stored, so they read as zero.
// A debug write takes priority over a processor write in the same cycle.
module sram_base_reg
    import sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BASE_W-1:0] cfg_base_in,
    input  logic              cfg_valid_in,
    input  logic              dbg_we,
    input  logic [BASE_W-1:0] dbg_base_in,
    input  logic              dbg_valid_in,
    output logic [BASE_W-1:0] base,
    output logic              valid,
    output logic [31:0]       rd_value
);

    // Valid bit: cleared by reset, debug write wins over processor write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      valid <= 1'b0;
        else if (dbg_we) valid <= dbg_valid_in;
        else if (cfg_we) valid <= cfg_valid_in;
    end

    // Base field: no reset, so it survives a reset.
    always_ff @(posedge clk) begin
        if (dbg_we)      base <= dbg_base_in;
        else if (cfg_we) base <= cfg_base_in;
    end

    // Read view: reserved bits are tied to zero.
    always_comb rd_value = {base, {(BASE_LSB-1){1'b0}}, valid};

endmodule

// File: rtl/sram_port_dec.sv
// Per-port decode: window hit, alignment check, bank select, word index,
// byte-lane enables and lane-shifted write data.
// Assumes address bit 2 selects the bank and bits above it index the bank.
module sram_port_dec
    import sram_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic              req,
    input  logic [1:0]        size,
    input  logic [31:0]       addr,
    input  logic [31:0]       wdata,
    input  logic [BASE_W-1:0] base,
    input  logic              valid,
    output logic              hit,
    output logic              misal,
    output logic              go,
    output logic              bank,
    output logic [IDX_W-1:0]  idx,
    output logic [3:0]        be,
    output logic [31:0]       wdata_lane
);

    // Window compare gated by the valid bit.
    always_comb hit = req && valid && (addr[31:BASE_LSB] == base);

    // Alignment and go decision.
    always_comb begin
        misal = is_misaligned(size, addr[1:0]);
        go    = hit && !misal;
    end

    // Bank, index and lane steering.
    always_comb begin
        bank       = addr[2];
        idx        = addr[IDX_W+2:3];
        be         = lane_mask(size, addr[1:0]);
        wdata_lane = wdata << {addr[1:0], 3'b000};
    end

endmodule

// File: rtl/sram_bank.sv
// One physical array: a single port with byte-lane writes and a registered
// read. Contents are not initialised. Read data updates only on a read.
module sram_bank #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [3:0]       be,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [31:0] mem [DEPTH];

    // Array access: lane-masked write or registered read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int l = 0; l < 4; l++) begin
                    if (be[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
                end
            end else begin
                rdata <= mem[idx];
            end
        end
    end

endmodule

// File: rtl/reloc_sram.sv
// Relocatable dual-bank scratchpad SRAM, top level.
// The processor and DMA ports share two longword-interleaved banks, and the
// processor wins a same-bank conflict. The processor read path overrides
// cache data after a hit.
// Assumes LWORDS is a power of two no larger than 16384 (64 KB).
module reloc_sram
    import sram_pkg::*;
#(
    parameter int LWORDS = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        dbg_we,
    input  logic [31:0] dbg_wdata,
    output logic [31:0] dbg_rdata,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    input  logic [31:0] cache_rdata,
    output logic        cpu_hit,
    output logic        cpu_nocache,
    output logic [31:0] cpu_rdata,
    output logic        cpu_err,
    input  logic        dma_req,
    input  logic        dma_we,
    input  logic [1:0]  dma_size,
    input  logic [31:0] dma_addr,
    input  logic [31:0] dma_wdata,
    output logic        dma_hit,
    output logic        dma_wait,
    output logic [31:0] dma_rdata,
    output logic        dma_err
);

    localparam int BANK_WORDS = LWORDS / 2;
    localparam int IDX_W      = $clog2(BANK_WORDS);

    logic [BASE_W-1:0] cfg_base;
    logic              cfg_valid;

    logic             cpu_misal, cpu_go, cpu_bank;
    logic [IDX_W-1:0] cpu_idx;
    logic [3:0]       cpu_be;
    logic [31:0]      cpu_wl;
    logic             dma_misal, dma_go, dma_bank, dma_do;
    logic [IDX_W-1:0] dma_idx;
    logic [3:0]       dma_be;
    logic [31:0]      dma_wl;

    logic [31:0] bank_q [2];

    logic       cpu_rd_q, cpu_bank_q, dma_bank_q;
    logic [1:0] cpu_off_q, cpu_sz_q, dma_off_q, dma_sz_q;

    sram_base_reg u_base (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_base_in  (cfg_wdata[31:BASE_LSB]),
        .cfg_valid_in (cfg_wdata[0]),
        .dbg_we       (dbg_we),
        .dbg_base_in  (dbg_wdata[31:BASE_LSB]),
        .dbg_valid_in (dbg_wdata[0]),
        .base         (cfg_base),
        .valid        (cfg_valid),
        .rd_value     (dbg_rdata)
    );

    sram_port_dec #(.IDX_W(IDX_W)) u_cpu_dec (
        .req (cpu_req), .size (cpu_size), .addr (cpu_addr), .wdata (cpu_wdata),
        .base (cfg_base), .valid (cfg_valid),
        .hit (cpu_hit), .misal (cpu_misal), .go (cpu_go), .bank (cpu_bank),
        .idx (cpu_idx), .be (cpu_be), .wdata_lane (cpu_wl)
    );

    sram_port_dec #(.IDX_W(IDX_W)) u_dma_dec (
        .req (dma_req), .size (dma_size), .addr (dma_addr), .wdata (dma_wdata),
        .base (cfg_base), .valid (cfg_valid),
        .hit (dma_hit), .misal (dma_misal), .go (dma_go), .bank (dma_bank),
        .idx (dma_idx), .be (dma_be), .wdata_lane (dma_wl)
    );

    // Conflict arbitration: the processor owns a contested bank.
    always_comb begin
        dma_wait    = cpu_go && dma_go && (cpu_bank == dma_bank);
        dma_do      = dma_go && !dma_wait;
        cpu_nocache = cpu_hit;
    end

    // One array per bank, each fed by whichever port owns it this cycle.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic             sel_cpu, sel_dma;
        logic             b_we;
        logic [3:0]       b_be;
        logic [IDX_W-1:0] b_idx;
        logic [31:0]      b_wd;

        // Port steering for this bank.
        always_comb begin
            sel_cpu = cpu_go && (cpu_bank == 1'(b));
            sel_dma = dma_do && (dma_bank == 1'(b));
            b_we    = sel_cpu ? cpu_we  : dma_we;
            b_be    = sel_cpu ? cpu_be  : dma_be;
            b_idx   = sel_cpu ? cpu_idx : dma_idx;
            b_wd    = sel_cpu ? cpu_wl  : dma_wl;
        end

        sram_bank #(.IDX_W(IDX_W)) u_arr (
            .clk   (clk),
            .en    (sel_cpu || sel_dma),
            .we    (b_we),
            .be    (b_be),
            .idx   (b_idx),
            .wdata (b_wd),
            .rdata (bank_q[b])
        );
    end

    // Read-return and error tracking per port.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_rd_q <= 1'b0;
            cpu_err  <= 1'b0;
            dma_err  <= 1'b0;
        end else begin
            cpu_rd_q <= cpu_go && !cpu_we;
            cpu_err  <= cpu_hit && cpu_misal;
            dma_err  <= dma_hit && dma_misal;
        end
    end

    // Capture of the bank, offset and size used to format read data.
    always_ff @(posedge clk) begin
        if (cpu_go && !cpu_we) begin
            cpu_bank_q <= cpu_bank;
            cpu_off_q  <= cpu_addr[1:0];
            cpu_sz_q   <= cpu_size;
        end
        if (dma_do && !dma_we) begin
            dma_bank_q <= dma_bank;
            dma_off_q  <= dma_addr[1:0];
            dma_sz_q   <= dma_size;
        end
    end

    // Read formatting and the cache-override mux.
    always_comb begin
        cpu_rdata = cpu_rd_q ? rd_extract(bank_q[cpu_bank_q], cpu_off_q, cpu_sz_q)
                             : cache_rdata;
        dma_rdata = rd_extract(bank_q[dma_bank_q], dma_off_q, dma_sz_q);
    end

endmodule

// File: rtl/reloc_sram_chk.sv
// Assertion checker for reloc_sram, attached by bind.
module reloc_sram_chk
    import sram_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_valid,
    input logic [BASE_W-1:0] cfg_base,
    input logic [31:0]       dbg_rdata,
    input logic              cpu_hit,
    input logic [1:0]        cpu_size,
    input logic [31:0]       cpu_addr,
    input logic              cpu_err,
    input logic [31:0]       cpu_rdata,
    input logic [31:0]       cache_rdata,
    input logic              dma_hit,
    input logic [31:0]       dma_addr,
    input logic              dma_wait
);

    // R1
    hit_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (cfg_valid && cpu_addr[31:16] == cfg_base));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rdata[15:1] == 15'd0);

    // R7
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hit && ((cpu_size == 2'b11) || (cpu_size == 2'b01 && cpu_addr[0])
                     || (cpu_size == 2'b10 && cpu_addr[1:0] != 2'b00))) |=> cpu_err);

    // R9
    dma_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wait |-> (cpu_hit && dma_hit && cpu_addr[2] == dma_addr[2]));

    // R10
    cache_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_hit) |-> (cpu_rdata == cache_rdata));

endmodule

bind reloc_sram reloc_sram_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid   (cfg_valid),
    .cfg_base    (cfg_base),
    .dbg_rdata   (dbg_rdata),
    .cpu_hit     (cpu_hit),
    .cpu_size    (cpu_size),
    .cpu_addr    (cpu_addr),
    .cpu_err     (cpu_err),
    .cpu_rdata   (cpu_rdata),
    .cache_rdata (cache_rdata),
    .dma_hit     (dma_hit),
    .dma_addr    (dma_addr),
    .dma_wait    (dma_wait)
);

// File: tb/reloc_sram_tb_top.sv
`timescale 1ns/1ps
// Directed bench for reloc_sram: one task per scenario, each checking its own results.
module reloc_sram_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, dbg_we = 1'b0;
    logic [31:0] cfg_wdata = '0, dbg_wdata = '0, dbg_rdata;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'b10;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0, cache_rdata = 32'hCAFE_0000;
    logic        cpu_hit, cpu_nocache, cpu_err;
    logic [31:0] cpu_rdata;
    logic        dma_req = 1'b0, dma_we = 1'b0;
    logic [1:0]  dma_size = 2'b10;
    logic [31:0] dma_addr = '0, dma_wdata = '0;
    logic        dma_hit, dma_wait, dma_err;
    logic [31:0] dma_rdata;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [31:0] BASE = 32'h1234_0000;

    always #2.5 clk = ~clk;

    reloc_sram dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .dbg_we (dbg_we), .dbg_wdata (dbg_wdata), .dbg_rdata (dbg_rdata),
        .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_size (cpu_size),
        .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata), .cache_rdata (cache_rdata),
        .cpu_hit (cpu_hit), .cpu_nocache (cpu_nocache), .cpu_rdata (cpu_rdata),
        .cpu_err (cpu_err),
        .dma_req (dma_req), .dma_we (dma_we), .dma_size (dma_size),
        .dma_addr (dma_addr), .dma_wdata (dma_wdata),
        .dma_hit (dma_hit), .dma_wait (dma_wait), .dma_rdata (dma_rdata),
        .dma_err (dma_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cpu_op(input logic we, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d);
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
        step();
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic dma_op(input logic we, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d);
        dma_req = 1'b1; dma_we = we; dma_size = sz; dma_addr = a; dma_wdata = d;
        step();
        dma_req = 1'b0; dma_we = 1'b0;
    endtask

    task automatic cpu_rd_chk(input string req, input logic [1:0] sz,
                              input logic [31:0] a, input logic [31:0] exp);
        cpu_op(1'b0, sz, a, 32'h0);
        chk(req, cpu_rdata, exp);
    endtask

    task automatic dma_rd_chk(input string req, input logic [1:0] sz,
                              input logic [31:0] a, input logic [31:0] exp);
        dma_op(1'b0, sz, a, 32'h0);
        chk(req, dma_rdata, exp);
    endtask

    // Reset state: valid clear, no hit, no error.
    task automatic t_reset();
        chk("R3 valid clear after reset", {31'b0, dbg_rdata[0]}, 32'h0);
        cpu_req = 1'b1; cpu_addr = BASE; #1;
        chk("R3 no hit after reset", {31'b0, cpu_hit}, 32'h0);
        cpu_req = 1'b0;
        chk("R7 err idle after reset", {31'b0, cpu_err}, 32'h0);
    endtask

    // Base register access, reserved bits and write priority.
    task automatic t_reg();
        cfg_we = 1'b1; cfg_wdata = 32'h1234_FFFF; step(); cfg_we = 1'b0;
        chk("R2 R4 cfg write, reserved read zero", dbg_rdata, 32'h1234_0001);
        dbg_we = 1'b1; dbg_wdata = 32'hABCD_0000; step(); dbg_we = 1'b0;
        chk("R4 debug write", dbg_rdata, 32'hABCD_0000);
        cfg_we = 1'b1; cfg_wdata = 32'h1111_0001;
        dbg_we = 1'b1; dbg_wdata = 32'h1234_0001;
        step();
        cfg_we = 1'b0; dbg_we = 1'b0;
        chk("R4 debug wins over cfg", dbg_rdata, 32'h1234_0001);
    endtask

    // Window decode and miss isolation.
    task automatic t_decode();
        cpu_req = 1'b1; cpu_addr = 32'h1235_0010; #1;
        chk("R1 miss one page above", {31'b0, cpu_hit}, 32'h0);
        cpu_addr = BASE + 32'h10; #1;
        chk("R1 hit in window", {30'b0, cpu_hit, cpu_nocache}, 32'h3);
        cpu_req = 1'b0;
        cpu_op(1'b1, 2'b10, BASE + 32'h10, 32'hA5A5_A5A5);
        cpu_op(1'b1, 2'b10, 32'h1235_0010, 32'h0000_0000);
        cpu_rd_chk("R1 miss write leaves memory", 2'b10, BASE + 32'h10, 32'hA5A5_A5A5);
    endtask

    // Lane steering for writes and reads of every size.
    task automatic t_lanes();
        cpu_op(1'b1, 2'b10, BASE + 32'h20, 32'h1122_3344);
        cpu_op(1'b1, 2'b00, BASE + 32'h21, 32'h0000_00AA);
        cpu_rd_chk("R5 byte write lane 1", 2'b10, BASE + 32'h20, 32'h1122_AA44);
        cpu_op(1'b1, 2'b01, BASE + 32'h22, 32'h0000_BEEF);
        cpu_rd_chk("R5 half write upper", 2'b10, BASE + 32'h20, 32'hBEEF_AA44);
        cpu_rd_chk("R6 byte read lane 3", 2'b00, BASE + 32'h23, 32'h0000_00BE);
        cpu_rd_chk("R6 half read lower", 2'b01, BASE + 32'h20, 32'h0000_AA44);
    endtask

    // Misaligned and reserved-size accesses.
    task automatic t_misalign();
        cpu_op(1'b1, 2'b01, BASE + 32'h21, 32'h0000_0000);
        chk("R7 odd half err", {31'b0, cpu_err}, 32'h1);
        cpu_op(1'b1, 2'b10, BASE + 32'h22, 32'h0000_0000);
        chk("R7 unaligned word err", {31'b0, cpu_err}, 32'h1);
        cpu_op(1'b1, 2'b11, BASE + 32'h20, 32'h0000_0000);
        chk("R7 reserved size err", {31'b0, cpu_err}, 32'h1);
        dma_op(1'b1, 2'b01, BASE + 32'h23, 32'h0000_0000);
        chk("R7 dma misaligned err", {31'b0, dma_err}, 32'h1);
        cpu_rd_chk("R7 memory unchanged", 2'b10, BASE + 32'h20, 32'hBEEF_AA44);
        chk("R7 err clears on good access", {31'b0, cpu_err}, 32'h0);
    endtask

    // Cache override on the processor read path.
    task automatic t_override();
        cache_rdata = 32'hCAFE_0001;
        cpu_op(1'b0, 2'b10, 32'h1235_0020, 32'h0);
        chk("R10 miss read passes cache", cpu_rdata, 32'hCAFE_0001);
        cpu_op(1'b0, 2'b10, BASE + 32'h20, 32'h0);
        chk("R10 hit read overrides cache", cpu_rdata, 32'hBEEF_AA44);
        step();
        chk("R10 idle returns cache", cpu_rdata, 32'hCAFE_0001);
    endtask

    // Concurrent access to opposite banks.
    task automatic t_banks();
        cpu_op(1'b1, 2'b10, BASE + 32'h40, 32'h0000_0040);
        dma_op(1'b1, 2'b10, BASE + 32'h44, 32'h0000_0044);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 2'b10; cpu_addr = BASE + 32'h40;
        cpu_wdata = 32'hC0C0_0040;
        dma_req = 1'b1; dma_we = 1'b1; dma_size = 2'b10; dma_addr = BASE + 32'h44;
        dma_wdata = 32'hD0D0_0044;
        #1;
        chk("R8 no wait on opposite banks", {31'b0, dma_wait}, 32'h0);
        step();
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = BASE + 32'h44;
        dma_req = 1'b1; dma_we = 1'b0; dma_addr = BASE + 32'h40;
        step();
        cpu_req = 1'b0; dma_req = 1'b0;
        chk("R8 cpu read bank 1", cpu_rdata, 32'hD0D0_0044);
        chk("R8 dma read bank 0", dma_rdata, 32'hC0C0_0040);
    endtask

    // Same-bank conflict: the processor wins.
    task automatic t_conflict();
        dma_op(1'b1, 2'b10, BASE + 32'h48, 32'h0000_0048);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 2'b10; cpu_addr = BASE + 32'h40;
        cpu_wdata = 32'h1111_1111;
        dma_req = 1'b1; dma_we = 1'b1; dma_size = 2'b10; dma_addr = BASE + 32'h48;
        dma_wdata = 32'h2222_2222;
        #1;
        chk("R9 dma wait on same bank", {31'b0, dma_wait}, 32'h1);
        step();
        cpu_req = 1'b0; cpu_we = 1'b0; dma_req = 1'b0; dma_we = 1'b0;
        cpu_rd_chk("R9 cpu write done", 2'b10, BASE + 32'h40, 32'h1111_1111);
        dma_rd_chk("R9 dma write dropped", 2'b10, BASE + 32'h48, 32'h0000_0048);
    endtask

    // Reset keeps the base field and memory, and clears valid.
    task automatic t_reset_keep();
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
        chk("R3 base kept, valid cleared", dbg_rdata, 32'h1234_0000);
        cpu_req = 1'b1; cpu_addr = BASE + 32'h20; #1;
        chk("R3 no hit while disabled", {31'b0, cpu_hit}, 32'h0);
        cpu_req = 1'b0;
        dbg_we = 1'b1; dbg_wdata = 32'h1234_0001; step(); dbg_we = 1'b0;
        cpu_rd_chk("R3 memory kept across reset", 2'b10, BASE + 32'h20, 32'hBEEF_AA44);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_reg();
        t_decode();
        t_lanes();
        t_misalign();
        t_override();
        t_banks();
        t_conflict();
        t_reset_keep();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule